// File: doc/BRIEF.md
# Dual-Mode Serial Sample Output Port

This block takes 16-bit two's-complement samples from one of two upstream filter stages and sends them to a host processor. It uses three lines: a bit clock, a data line and a frame marker. All timing comes from one master clock. A source-select input picks the slower final-filter stream or the faster first-stage comb stream. That choice sets the bit clock divisor and the frame length. In final-filter mode, a format input picks between a one-bit-wide high marker and a word-wide low marker.

Each upstream source writes its sample into a holding register when its valid strobe is high. At the first position of every frame, the holding register of the selected source is copied into the shift register, and the word then goes out sign bit first. An external sync input, sampled on the falling master edge, lets several ports be restarted onto a common frame phase. An active-low enable drives the data line's output-enable at once, with no clock involved. The pad tristate cell sits outside the block.

Top module: `ser_sample_port`

## Requirements
- R1: With `sel_comb` = 0, `sclk` has a period of 4 master clocks and is high for the first 2 of them. A frame lasts 128 master clocks, which is 32 bit periods.
- R2: With `sel_comb` = 1, `sclk` has a period of 2 master clocks and is high for the first of them. A frame lasts 32 master clocks, which is 16 bit periods.
- R3: During bit period b of a frame (b = 0..15), `sdata` carries bit 15-b of the frame's word, so the sign bit goes first. `sdata` changes only when `sclk` rises. In the remaining bit periods of a frame, `sdata` is 0.
- R4: A sample is held when its valid strobe is high on a rising edge. The frame's word is the held value of the selected source just before the rising edge that shows frame position 0. A sample that arrives on that edge, or later in the frame, goes out in the next frame. A sample from the unselected source is never sent.
- R5: With `sel_comb` = 0 and format 0, `fsync` is high during bit period 0 and low otherwise. With format 1, `fsync` is low during bit periods 0..15 and high during 16..31.
- R6: With `sel_comb` = 1, `fmt_word` has no effect and `fsync` follows format 0.
- R7: `ext_sync` is sampled on the falling master edge. A low-to-high change seen at falling edge F makes the outputs show frame position 0 after the second rising edge following F. The frame in progress is cut short.
- R8: While `ext_sync` stays low or stays high, frames repeat back to back with no restart.
- R9: `sdata_oe` equals the inverse of `oe_n` at all times, with no clock involved. `oe_n` has no effect on `sclk` or `fsync`.
- R10: A change of `sel_comb` or `fmt_word` takes effect only at the next frame start, whether that comes from a natural wrap or from a restart.
- R11: `rst` is synchronous and active high. While it is asserted, `sclk`, `fsync` and `sdata` are 0 and both holding registers are cleared. The first rising edge after release shows frame position 0, in the mode and format that were present during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_comb | input | 1 | Source select: 0 final-filter, 1 comb |
| fmt_word | input | 1 | Frame marker shape in final-filter mode |
| fir_data | input | WORD_W | Final-filter sample |
| fir_vld | input | 1 | Final-filter sample strobe |
| comb_data | input | WORD_W | Comb sample |
| comb_vld | input | 1 | Comb sample strobe |
| ext_sync | input | 1 | External frame restart, active high |
| oe_n | input | 1 | Asynchronous active-low data enable |
| sclk | output | 1 | Serial bit clock |
| fsync | output | 1 | Frame marker |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Output enable for the data pad |

## Verification
Two functions can land on the same master edge. A sample strobe can coincide with the load of the shift register at frame position 0, and an external restart can coincide with the natural wrap from the last frame position. The bench provokes the first by raising a valid strobe exactly when its frame model reaches position 0. It provokes the second by raising `ext_sync` when the model reaches the last position. The first is judged by the word sent in that frame and in the following one. The second is judged by an unbroken following frame, with a mode change arranged to take effect at that same edge.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;
  typedef enum logic {
    SRC_FINAL = 1'b0,
    SRC_COMB  = 1'b1
  } src_e;
endpackage

// File: rtl/ser_sync_in.sv
module ser_sync_in (
  input  logic clk,
  input  logic rst,
  input  logic ext_sync,
  output logic restart
);
  logic smp_fall;
  logic smp_prev;

  // external sync is captured on the falling master edge
  always_ff @(negedge clk) begin
    if (rst) smp_fall <= 1'b0;
    else     smp_fall <= ext_sync;
  end

  always_ff @(posedge clk) begin
    if (rst) smp_prev <= 1'b0;
    else     smp_prev <= smp_fall;
  end

  assign restart = smp_fall & ~smp_prev;
endmodule

// File: rtl/ser_frame_timer.sv
module ser_frame_timer
  import ser_port_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int FINAL_DIV  = 4,
  parameter int COMB_DIV   = 2,
  parameter int FINAL_BITS = 32,
  parameter int COMB_BITS  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic sel_comb,
  input  logic fmt_word,
  output logic sclk_o,
  output logic fsync_o,
  output logic load_stb,
  output logic shift_stb,
  output src_e mode_cur
);
  localparam int FINAL_LEN = FINAL_DIV * FINAL_BITS;
  localparam int COMB_LEN  = COMB_DIV * COMB_BITS;
  localparam int CNT_W     = $clog2(FINAL_LEN);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] sub;
  logic [CNT_W-1:0] bidx;
  logic [CNT_W-1:0] half;
  logic             fmt_cur;
  logic             fmt_eff;
  logic             at_last;

  always_comb begin
    if (mode_cur == SRC_COMB) begin
      sub  = cnt % CNT_W'(COMB_DIV);
      bidx = cnt / CNT_W'(COMB_DIV);
      half = CNT_W'(COMB_DIV / 2);
      last = CNT_W'(COMB_LEN - 1);
    end else begin
      sub  = cnt % CNT_W'(FINAL_DIV);
      bidx = cnt / CNT_W'(FINAL_DIV);
      half = CNT_W'(FINAL_DIV / 2);
      last = CNT_W'(FINAL_LEN - 1);
    end
    at_last   = (cnt == last);
    fmt_eff   = fmt_cur & (mode_cur == SRC_FINAL);
    load_stb  = (cnt == '0);
    shift_stb = (sub == '0) && (cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      mode_cur <= src_e'(sel_comb);
      fmt_cur  <= fmt_word;
      sclk_o   <= 1'b0;
      fsync_o  <= 1'b0;
    end else begin
      sclk_o  <= (sub < half);
      fsync_o <= fmt_eff ? (bidx >= CNT_W'(WORD_W)) : (bidx == '0);
      if (restart || at_last) begin
        cnt      <= '0;
        mode_cur <= src_e'(sel_comb);
        fmt_cur  <= fmt_word;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_COMB_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (mode_cur == SRC_COMB) |-> (cnt <= CNT_W'(COMB_LEN - 1))); // R2

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0)); // R7

  AST_MODE_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_cur) |-> (cnt == '0)); // R10

  AST_FMT_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(fmt_cur) |-> (cnt == '0)); // R10
endmodule

// File: rtl/ser_word_shifter.sv
module ser_word_shifter
  import ser_port_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int N_SRC  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_SRC-1:0][WORD_W-1:0] src_data,
  input  logic [N_SRC-1:0]              src_vld,
  input  src_e                          mode_cur,
  input  logic                          load_stb,
  input  logic                          shift_stb,
  output logic                          sdata_o
);
  logic [WORD_W-1:0] hold [N_SRC];
  logic [WORD_W-1:0] sr;
  logic [WORD_W-1:0] load_word;

  for (genvar s = 0; s < N_SRC; s++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)             hold[s] <= '0;
      else if (src_vld[s]) hold[s] <= src_data[s];
    end
  end

  assign load_word = (mode_cur == SRC_COMB) ? hold[1] : hold[0];

  always_ff @(posedge clk) begin
    if (rst)            sr <= '0;
    else if (load_stb)  sr <= load_word;
    else if (shift_stb) sr <= {sr[WORD_W-2:0], 1'b0};
  end

  assign sdata_o = sr[WORD_W-1];

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load_stb, shift_stb})); // R3

  AST_SHIFT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && !shift_stb) |=> $stable(sr)); // R3
endmodule

// File: rtl/ser_sample_port.sv
module ser_sample_port
  import ser_port_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int FINAL_DIV  = 4,
  parameter int COMB_DIV   = 2,
  parameter int FINAL_BITS = 32,
  parameter int COMB_BITS  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_comb,
  input  logic              fmt_word,
  input  logic [WORD_W-1:0] fir_data,
  input  logic              fir_vld,
  input  logic [WORD_W-1:0] comb_data,
  input  logic              comb_vld,
  input  logic              ext_sync,
  input  logic              oe_n,
  output logic              sclk,
  output logic              fsync,
  output logic              sdata,
  output logic              sdata_oe
);
  logic restart;
  logic load_stb;
  logic shift_stb;
  src_e mode_cur;

  ser_sync_in u_sync (
    .clk      (clk),
    .rst      (rst),
    .ext_sync (ext_sync),
    .restart  (restart)
  );

  ser_frame_timer #(
    .WORD_W     (WORD_W),
    .FINAL_DIV  (FINAL_DIV),
    .COMB_DIV   (COMB_DIV),
    .FINAL_BITS (FINAL_BITS),
    .COMB_BITS  (COMB_BITS)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .sel_comb  (sel_comb),
    .fmt_word  (fmt_word),
    .sclk_o    (sclk),
    .fsync_o   (fsync),
    .load_stb  (load_stb),
    .shift_stb (shift_stb),
    .mode_cur  (mode_cur)
  );

  ser_word_shifter #(
    .WORD_W (WORD_W),
    .N_SRC  (2)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .src_data  ({comb_data, fir_data}),
    .src_vld   ({comb_vld, fir_vld}),
    .mode_cur  (mode_cur),
    .load_stb  (load_stb),
    .shift_stb (shift_stb),
    .sdata_o   (sdata)
  );

  // enable path bypasses every register
  assign sdata_oe = ~oe_n;
endmodule

// File: tb/sim_ser_sample_port.sv
module sim_ser_sample_port;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst, sel_comb, fmt_word, fir_vld, comb_vld, ext_sync, oe_n;
  logic [W-1:0] fir_data, comb_data;
  logic         sclk, fsync, sdata, sdata_oe;

  always #5 clk = ~clk;

  ser_sample_port u0 (
    .clk(clk), .rst(rst), .sel_comb(sel_comb), .fmt_word(fmt_word),
    .fir_data(fir_data), .fir_vld(fir_vld), .comb_data(comb_data),
    .comb_vld(comb_vld), .ext_sync(ext_sync), .oe_n(oe_n),
    .sclk(sclk), .fsync(fsync), .sdata(sdata), .sdata_oe(sdata_oe)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string ptag  = "R11";

  // requirement-level frame model
  int           m_cnt;
  logic         m_mode, m_fmt, m_prev_ext;
  logic [W-1:0] m_hold [2];
  logic [W-1:0] m_word;
  logic         e_sclk, e_fsync, e_sdata, e_mode;

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s): actual=%b expected=%b at %0t", tag, ptag, act, exp, $time);
    end
  endtask

  task automatic step();
    int div, len, disp, b;
    logic rs;
    @(posedge clk);
    if (rst) begin
      m_cnt = 0; m_mode = sel_comb; m_fmt = fmt_word; m_prev_ext = 1'b0;
      m_hold[0] = '0; m_hold[1] = '0; m_word = '0;
      e_sclk = 1'b0; e_fsync = 1'b0; e_sdata = 1'b0; e_mode = sel_comb;
    end else begin
      div  = m_mode ? 2 : 4;
      len  = m_mode ? 32 : 128;
      disp = m_cnt;
      b    = disp / div;
      e_mode = m_mode;
      if (disp == 0) m_word = m_mode ? m_hold[1] : m_hold[0];
      e_sclk  = (disp % div) < (div / 2);
      e_fsync = (m_fmt && !m_mode) ? (b >= 16) : (b == 0);
      e_sdata = (b < 16) ? m_word[15-b] : 1'b0;
      if (fir_vld)  m_hold[0] = fir_data;
      if (comb_vld) m_hold[1] = comb_data;
      rs = ext_sync && !m_prev_ext;
      m_prev_ext = ext_sync;
      if (rs || disp == len - 1) begin
        m_cnt = 0; m_mode = sel_comb; m_fmt = fmt_word;
      end else begin
        m_cnt++;
      end
    end
    #3;
    if (rst) begin
      chk("R11 sclk", sclk, 1'b0);
      chk("R11 fsync", fsync, 1'b0);
      chk("R11 sdata", sdata, 1'b0);
    end else begin
      chk(e_mode ? "R2 sclk" : "R1 sclk", sclk, e_sclk);
      chk(e_mode ? "R6 fsync" : "R5 fsync", fsync, e_fsync);
      chk("R3 R4 sdata", sdata, e_sdata);
    end
    chk("R9 oe", sdata_oe, ~oe_n);
  endtask

  task automatic run(int n);
    repeat (n) step();
  endtask

  task automatic wait_pos(int p);
    while (m_cnt != p) step();
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL R11 watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] pats [4];
    pats[0] = 16'h8000; pats[1] = 16'h7FFF; pats[2] = 16'hA5C3; pats[3] = 16'h0001;
    rst = 1'b1; sel_comb = 1'b0; fmt_word = 1'b0; fir_vld = 1'b0; comb_vld = 1'b0;
    ext_sync = 1'b0; oe_n = 1'b0; fir_data = '0; comb_data = '0;

    // R11: reset state, strobe during reset ignored
    ptag = "R11";
    fir_data = 16'hFFFF; fir_vld = 1'b1;
    run(3);
    fir_vld = 1'b0; rst = 1'b0;
    #1;
    chk("R11 idle sclk", sclk, 1'b0);
    chk("R11 idle fsync", fsync, 1'b0);
    run(130);

    // R1 R3 R5: final mode, pulse marker, several words
    ptag = "R1";
    for (int k = 0; k < 4; k++) begin
      run(10 + k * 17);
      fir_data = pats[k]; fir_vld = 1'b1;
      step();
      fir_vld = 1'b0;
      comb_data = ~pats[k]; comb_vld = 1'b1;   // R4: unselected source
      step();
      comb_vld = 1'b0;
      wait_pos(0);
    end
    run(130);

    // R4: strobe on the load edge goes to the next frame
    ptag = "R4";
    wait_pos(0);
    fir_data = 16'h1234; fir_vld = 1'b1;
    step();
    fir_vld = 1'b0;
    run(260);

    // R10 R5: format change mid-frame
    ptag = "R10";
    run(40);
    fmt_word = 1'b1;
    fir_data = 16'hC3A5; fir_vld = 1'b1; step(); fir_vld = 1'b0;
    run(300);

    // R2 R6: comb mode with format still 1
    ptag = "R6";
    run(21);
    sel_comb = 1'b1;
    for (int k = 0; k < 6; k++) begin
      run(5 + k * 3);
      comb_data = pats[k % 4] ^ 16'(k * 16'h0F0F); comb_vld = 1'b1;
      step();
      comb_vld = 1'b0;
      wait_pos(0);
    end
    ptag = "R2";
    run(70);

    // R7: restart mid-frame in comb mode
    ptag = "R7";
    run(9);
    ext_sync = 1'b1; step(); ext_sync = 1'b0;
    run(70);

    // R8: sync held high, no further restarts
    ptag = "R8";
    ext_sync = 1'b1;
    run(100);
    ext_sync = 1'b0;
    run(40);

    // R7 R10: restart on the last position, mode change at that edge
    ptag = "R10";
    wait_pos(31);
    sel_comb = 1'b0; fmt_word = 1'b0; ext_sync = 1'b1;
    step();
    ext_sync = 1'b0;
    fir_data = 16'h5A5A; fir_vld = 1'b1; step(); fir_vld = 1'b0;
    run(270);

    // R7: restart mid-frame in final mode
    ptag = "R7";
    run(50);
    ext_sync = 1'b1; step(); ext_sync = 1'b0;
    run(200);

    // R9: asynchronous data enable
    ptag = "R9";
    run(7);
    oe_n = 1'b1; #1;
    chk("R9 oe off immediate", sdata_oe, 1'b0);
    run(40);
    oe_n = 1'b0; #1;
    chk("R9 oe on immediate", sdata_oe, 1'b1);
    run(20);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule